// File: doc/BRIEF.md
# Flash Initialization Area Loader

This block runs once after device configuration. When its start input pulses, it reads a small header from flash page zero. The header gives the first page of an initialization area and the number of pages in it. The block then reads the first four bytes of that start page and compares them with a fixed signature, 3C A5 0F 96. Only when all four bytes match does it stream the area, one byte at a time, to a downstream consumer over a valid/ready byte interface.

The flash side is a simple page-and-offset read port. The block raises a one-cycle read request with a page number and a byte offset, then waits for a data strobe. Only one read is ever in flight. Reads are paced by the consumer: while the consumer holds ready low, no new flash read is issued, so no byte is lost or repeated.

An empty area (page count zero) ends the load at once with a no-data flag. A signature mismatch ends it with a bad-signature flag and sends nothing. This keeps blank or foreign flash contents away from the consumer.

Top module: `fil_init_loader`

## Requirements
- R1: After a start pulse from the idle state, the block reads page 0 at byte offsets 0, 1, 2 and 3 in that order. The start page is taken from bytes 0 and 1, most significant byte first. The page count is taken from bytes 2 and 3, most significant byte first.
- R2: A read is a one-cycle pulse on `flash_rd`. No further pulse appears until `flash_rvalid` has returned the data for the previous one.
- R3: A page count of 0 sets `done` and `no_data`. No output byte is sent and no further flash read occurs.
- R4: Offsets 0 to 3 of the start page are read and compared with 3C, A5, 0F, 96 (offset 0 holds 3C) before any byte is offered on the output.
- R5: If any signature byte differs, `bad_sig` and `done` are set. Reading stops at the first differing byte, and no output byte is sent.
- R6: With `FWD_SIG`=1 (default), the output stream is the four signature bytes followed by every following byte of the area. This makes count × `PAGE_BYTES` bytes in total, each equal to the flash content at its position.
- R7: Pages are read in ascending order from the start page through start + count − 1, wrapping modulo 2^16. Within each page the offsets run from 0 upward to `PAGE_BYTES`−1.
- R8: A byte is transferred when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `out_data` stays stable. No byte is dropped or duplicated.
- R9: `done` rises after the last byte is accepted. `done`, `no_data` and `bad_sig` then hold until reset. A later start pulse causes no read and no output.
- R10: After reset, `done`, `no_data`, `bad_sig`, `out_valid` and `flash_rd` are low, and no read occurs until start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins the one-time load |
| flash_rd | output | 1 | One-cycle flash read request |
| flash_page | output | 16 | Page number of the request |
| flash_offs | output | OFFS_W | Byte offset within the page |
| flash_rvalid | input | 1 | Read data strobe |
| flash_rdata | input | 8 | Read data byte |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | Load finished (sticky) |
| no_data | output | 1 | Area length was zero (sticky) |
| bad_sig | output | 1 | Signature mismatch (sticky) |

## Verification
A wrong page or offset counter shows up on the read port at the first wrapping read. It also shows up on the output as a wrong byte value within one read latency of the fault. A stuck or lost pending-read flag shows up either as a second request before the data strobe or as a hang that keeps `done` low. A wrong signature decision is visible when the first output byte appears, or when `bad_sig` or `done` rises, a few cycles after the fourth signature read. Flags that fail to hold, or a start that is accepted again, show up on the read port and the status pins in the quiet cycles after `done`.

// File: rtl/fil_pkg.sv
package fil_pkg;

   localparam int HDR_W   = 16;
   localparam int SIG_LEN = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_SIG,
      ST_EMIT,
      ST_DATA,
      ST_DONE
   } fil_state_e;

   function automatic logic [7:0] sig_byte(input logic [1:0] idx);
      case (idx)
         2'd0:    sig_byte = 8'h3C;
         2'd1:    sig_byte = 8'hA5;
         2'd2:    sig_byte = 8'h0F;
         default: sig_byte = 8'h96;
      endcase
   endfunction

endpackage

// File: rtl/fil_addr_gen.sv
module fil_addr_gen #(
   parameter int PAGE_BYTES = 256,
   parameter int PAGE_W     = 16,
   parameter int OFFS_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [PAGE_W-1:0] count_i,
   input  logic              step,
   output logic [PAGE_W-1:0] page_o,
   output logic [OFFS_W-1:0] offs_o,
   output logic              last_o
);

   localparam logic [OFFS_W-1:0] OFFS_MAX = OFFS_W'(PAGE_BYTES - 1);

   logic [PAGE_W-1:0] page_q, left_q;
   logic [OFFS_W-1:0] offs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         left_q <= '0;
         offs_q <= '0;
      end else if (load) begin
         page_q <= page_i;
         left_q <= count_i;
         offs_q <= '0;
      end else if (step) begin
         if (offs_q == OFFS_MAX) begin
            offs_q <= '0;
            page_q <= page_q + PAGE_W'(1);
            left_q <= left_q - PAGE_W'(1);
         end else begin
            offs_q <= offs_q + OFFS_W'(1);
         end
      end
   end

   assign page_o = page_q;
   assign offs_o = offs_q;
   assign last_o = (offs_q == OFFS_MAX) && (left_q == PAGE_W'(1));

   // R7: page advances by one when the offset wraps
   assert_page_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && offs_q == OFFS_MAX) |=> (offs_q == '0 && page_q == $past(page_q) + PAGE_W'(1)));

   // R7: offset ascends by one inside a page
   assert_offs_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && offs_q != OFFS_MAX) |=> (offs_q == $past(offs_q) + OFFS_W'(1) && $stable(page_q)));

endmodule

// File: rtl/fil_sig_check.sv
module fil_sig_check
   import fil_pkg::*;
(
   input  logic [1:0] idx,
   input  logic [7:0] rd_byte,
   output logic [7:0] exp_byte,
   output logic       match
);

   assign exp_byte = sig_byte(idx);
   assign match    = (rd_byte == exp_byte);

endmodule

// File: rtl/fil_out_stage.sv
module fil_out_stage #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] dout
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   // R8: a stalled byte stays put
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(dout)));

   // R8: a new byte never overwrites one not yet taken
   assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !valid);

endmodule

// File: rtl/fil_init_loader.sv
module fil_init_loader
   import fil_pkg::*;
#(
   parameter int PAGE_BYTES = 256,
   parameter bit FWD_SIG    = 1'b1,
   parameter int OFFS_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              flash_rd,
   output logic [HDR_W-1:0]  flash_page,
   output logic [OFFS_W-1:0] flash_offs,
   input  logic              flash_rvalid,
   input  logic [7:0]        flash_rdata,
   output logic              out_valid,
   output logic [7:0]        out_data,
   input  logic              out_ready,
   output logic              done,
   output logic              no_data,
   output logic              bad_sig
);

   localparam logic [OFFS_W-1:0] SIG_LAST = OFFS_W'(SIG_LEN - 1);

   if (PAGE_BYTES < 2 * SIG_LEN || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 8");
   end
   if (OFFS_W != $clog2(PAGE_BYTES)) begin : g_bad_offs
      $error("OFFS_W must equal clog2(PAGE_BYTES)");
   end

   fil_state_e st_q, st_d, after_sig;

   if (FWD_SIG) begin : g_fwd
      assign after_sig = ST_EMIT;
   end else begin : g_nofwd
      assign after_sig = ST_DATA;
   end

   logic             rd_pend_q, data_end_q, sig_ok_q, no_data_q, bad_sig_q;
   logic [23:0]      hdr_q;
   logic [2:0]       eidx_q;
   logic             cap;
   logic             ag_load, ag_step, ag_last;
   logic [HDR_W-1:0] ag_page, ag_count, ag_page_o;
   logic [OFFS_W-1:0] ag_offs;
   logic             o_load;
   logic [7:0]       o_din;
   logic [1:0]       sc_idx;
   logic [7:0]       sc_exp;
   logic             sc_match;
   logic             set_no_data, set_bad, set_sig_ok, set_data_end, emit_inc;
   logic [HDR_W-1:0] hdr_start, hdr_cnt;

   assign cap       = rd_pend_q && flash_rvalid;
   assign hdr_start = hdr_q[23:8];
   assign hdr_cnt   = {hdr_q[7:0], flash_rdata};
   assign sc_idx    = (st_q == ST_EMIT) ? eidx_q[1:0] : ag_offs[1:0];

   fil_addr_gen #(.PAGE_BYTES(PAGE_BYTES), .PAGE_W(HDR_W), .OFFS_W(OFFS_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(ag_load), .page_i(ag_page), .count_i(ag_count),
      .step(ag_step), .page_o(ag_page_o), .offs_o(ag_offs), .last_o(ag_last)
   );

   fil_sig_check u_sig (
      .idx(sc_idx), .rd_byte(flash_rdata), .exp_byte(sc_exp), .match(sc_match)
   );

   fil_out_stage #(.DW(8)) u_out (
      .clk(clk), .rst_n(rst_n), .load(o_load), .din(o_din), .ready(out_ready),
      .valid(out_valid), .dout(out_data)
   );

   assign flash_rd   = !rd_pend_q && (st_q == ST_HDR || st_q == ST_SIG ||
                       (st_q == ST_DATA && !out_valid && !data_end_q));
   assign flash_page = ag_page_o;
   assign flash_offs = ag_offs;

   always_comb begin
      st_d         = st_q;
      ag_load      = 1'b0;
      ag_step      = 1'b0;
      ag_page      = '0;
      ag_count     = '0;
      o_load       = 1'b0;
      o_din        = flash_rdata;
      set_no_data  = 1'b0;
      set_bad      = 1'b0;
      set_sig_ok   = 1'b0;
      set_data_end = 1'b0;
      emit_inc     = 1'b0;
      case (st_q)
         ST_IDLE: if (start) begin
            ag_load  = 1'b1;
            ag_count = HDR_W'(1);
            st_d     = ST_HDR;
         end
         ST_HDR: if (cap) begin
            ag_step = 1'b1;
            if (ag_offs == SIG_LAST) begin
               if (hdr_cnt == '0) begin
                  set_no_data = 1'b1;
                  st_d        = ST_DONE;
               end else begin
                  ag_load  = 1'b1;
                  ag_page  = hdr_start;
                  ag_count = hdr_cnt;
                  st_d     = ST_SIG;
               end
            end
         end
         ST_SIG: if (cap) begin
            if (!sc_match) begin
               set_bad = 1'b1;
               st_d    = ST_DONE;
            end else begin
               ag_step = 1'b1;
               if (ag_offs == SIG_LAST) begin
                  set_sig_ok = 1'b1;
                  st_d       = after_sig;
               end
            end
         end
         ST_EMIT: if (!out_valid) begin
            if (eidx_q == 3'(SIG_LEN)) begin
               st_d = ST_DATA;
            end else begin
               o_load   = 1'b1;
               o_din    = sc_exp;
               emit_inc = 1'b1;
            end
         end
         ST_DATA: if (cap) begin
            o_load  = 1'b1;
            ag_step = 1'b1;
            if (ag_last) set_data_end = 1'b1;
         end else if (data_end_q && !out_valid) begin
            st_d = ST_DONE;
         end
         ST_DONE: ;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         rd_pend_q  <= 1'b0;
         hdr_q      <= '0;
         eidx_q     <= '0;
         data_end_q <= 1'b0;
         sig_ok_q   <= 1'b0;
         no_data_q  <= 1'b0;
         bad_sig_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (flash_rd)   rd_pend_q <= 1'b1;
         else if (cap)   rd_pend_q <= 1'b0;
         if (st_q == ST_HDR && cap) hdr_q <= {hdr_q[15:0], flash_rdata};
         if (emit_inc)     eidx_q     <= eidx_q + 3'd1;
         if (set_data_end) data_end_q <= 1'b1;
         if (set_sig_ok)   sig_ok_q   <= 1'b1;
         if (set_no_data)  no_data_q  <= 1'b1;
         if (set_bad)      bad_sig_q  <= 1'b1;
      end
   end

   assign done    = (st_q == ST_DONE);
   assign no_data = no_data_q;
   assign bad_sig = bad_sig_q;

   // R1: header reads address page zero
   assert_hdr_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HDR && flash_rd) |-> (flash_page == '0));

   // R2: a request pulse lasts one cycle
   assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flash_rd |=> !flash_rd);

   // R3: empty area is silent
   assert_nodata_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      no_data |-> (done && !out_valid && !flash_rd && !bad_sig));

   // R4: nothing leaves before the signature passed
   assert_sig_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> sig_ok_q);

   // R5: mismatch is silent
   assert_bad_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_sig |-> (done && !out_valid && !flash_rd));

   // R9: status is sticky
   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(no_data) && $stable(bad_sig)));

endmodule

// File: tb/sim_fil_init_loader.sv
module sim_fil_init_loader;

   localparam int CLK_PERIOD = 10;
   localparam int PB         = 256;
   localparam int OW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          flash_rd;
   logic [15:0]   flash_page;
   logic [OW-1:0] flash_offs;
   logic          flash_rvalid = 1'b0;
   logic [7:0]    flash_rdata = 8'h00;
   logic          out_valid;
   logic [7:0]    out_data;
   logic          out_ready = 1'b0;
   logic          done, no_data, bad_sig;

   fil_init_loader #(.PAGE_BYTES(PB), .FWD_SIG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .flash_rd(flash_rd),
      .flash_page(flash_page), .flash_offs(flash_offs), .flash_rvalid(flash_rvalid),
      .flash_rdata(flash_rdata), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready), .done(done), .no_data(no_data), .bad_sig(bad_sig)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, failures = 0;
   int cfg_start, cfg_count, cfg_bad, cfg_pct;
   int fl_cnt, fl_pg, fl_off;
   int n_reads, n_out, rd_err, r2_err, data_err, stab_err;
   int rd_act, rd_exp, d_act, d_exp;
   bit hold;
   logic [7:0] hold_data;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] sig_of(input int i);
      case (i)
         0: return 8'h3C;
         1: return 8'hA5;
         2: return 8'h0F;
         default: return 8'h96;
      endcase
   endfunction

   function automatic logic [7:0] flash_byte(input int pg, input int off);
      logic [7:0] b;
      if (pg == 0 && off < 4) begin
         case (off)
            0: b = 8'((cfg_start >> 8) & 255);
            1: b = 8'(cfg_start & 255);
            2: b = 8'((cfg_count >> 8) & 255);
            default: b = 8'(cfg_count & 255);
         endcase
      end else if (pg == cfg_start && off < 4) begin
         b = sig_of(off);
         if (off == cfg_bad) b = b ^ 8'h5A;
      end else begin
         b = 8'((pg * 7 + off * 13 + 5) & 255);
      end
      return b;
   endfunction

   // encoded page*PB + offset of the n-th expected read
   function automatic int exp_read(input int n);
      int m;
      if (n < 4) return n;
      m = n - 4;
      return (((cfg_start + m / PB) % 65536) * PB) + (m % PB);
   endfunction

   function automatic logic [7:0] exp_out(input int j);
      return flash_byte((cfg_start + j / PB) % 65536, j % PB);
   endfunction

   task automatic step();
      int a;
      @(negedge clk);
      flash_rvalid = 1'b0;
      if (fl_cnt > 0) begin
         fl_cnt--;
         if (fl_cnt == 0) begin
            flash_rvalid = 1'b1;
            flash_rdata  = flash_byte(fl_pg, fl_off);
         end
      end
      if (flash_rd) begin
         if (fl_cnt > 0 || flash_rvalid) r2_err++;
         a = int'(flash_page) * PB + int'(flash_offs);
         if (a != exp_read(n_reads) && rd_err == 0) begin
            rd_act = a; rd_exp = exp_read(n_reads);
         end
         if (a != exp_read(n_reads)) rd_err++;
         n_reads++;
         fl_pg  = int'(flash_page);
         fl_off = int'(flash_offs);
         fl_cnt = 1 + int'($urandom % 3);
      end
      if (hold && !(out_valid && out_data == hold_data)) stab_err++;
      out_ready = (int'($urandom % 100) < cfg_pct);
      if (out_valid && out_ready) begin
         if (out_data != exp_out(n_out)) begin
            if (data_err == 0) begin d_act = out_data; d_exp = exp_out(n_out); end
            data_err++;
         end
         n_out++;
         hold = 1'b0;
      end else if (out_valid) begin
         hold = 1'b1;
         hold_data = out_data;
      end else begin
         hold = 1'b0;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start = 1'b0;
      fl_cnt = 0; n_reads = 0; n_out = 0; rd_err = 0; r2_err = 0;
      data_err = 0; stab_err = 0; hold = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      repeat (3) step();
      // R10: idle after reset, no read before start
      check(!done && !no_data && !bad_sig, "R10 reset status", {done, no_data, bad_sig}, 0);
      check(!out_valid && n_reads == 0, "R10 reset quiet", n_reads + int'(out_valid), 0);
   endtask

   task automatic run_scenario(input int st, input int cnt, input int bad, input int pct);
      int t, er, eo;
      cfg_start = st; cfg_count = cnt; cfg_bad = bad; cfg_pct = pct;
      do_reset();
      start = 1'b1;
      step();
      start = 1'b0;
      t = 0;
      while (!done && t < 20000) begin step(); t++; end
      repeat (30) step();
      if (cnt == 0)      begin er = 4;            eo = 0;        end
      else if (bad >= 0) begin er = 4 + bad + 1;  eo = 0;        end
      else               begin er = 4 + cnt * PB; eo = cnt * PB; end
      check(done, "R9 done raised", done, 1);
      check(no_data == (cnt == 0), "R3 no_data flag", no_data, cnt == 0);
      check(bad_sig == (cnt != 0 && bad >= 0), "R5 bad_sig flag", bad_sig, cnt != 0 && bad >= 0);
      check(n_reads == er, "R1 R5 R7 read count", n_reads, er);
      check(rd_err == 0, "R7 read order", rd_act, rd_exp);
      check(r2_err == 0, "R2 single outstanding read", r2_err, 0);
      check(n_out == eo, "R3 R5 R6 output byte count", n_out, eo);
      check(data_err == 0, "R4 R6 output content", d_act, d_exp);
      check(stab_err == 0, "R8 stall stability", stab_err, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int rn, ro;
      void'($urandom(32'd7331));
      run_scenario(16'h0123, 0, -1, 100);              // R3 empty area
      for (int k = 0; k < 4; k++)
         run_scenario(16'h0040, 1, k, 100);             // R5 each signature byte
      run_scenario(16'h0010, 1, -1, 100);              // R6 single page, no stalls
      run_scenario(16'h0200, 3, -1, 40);               // R8 heavy back-pressure
      run_scenario(16'hFFFF, 2, -1, 70);               // R7 page number wrap
      // R9: a second start after done is ignored
      rn = n_reads; ro = n_out;
      start = 1'b1; step(); start = 1'b0;
      repeat (40) step();
      check(n_reads == rn && n_out == ro, "R9 restart ignored", n_reads + n_out, rn + ro);
      check(done && !bad_sig && !no_data, "R9 flags held", {done, no_data, bad_sig}, 4);
      for (int i = 0; i < 3; i++)
         run_scenario(1 + int'($urandom % 4000), 1 + int'($urandom % 2), -1,
                      30 + int'($urandom % 71));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule